// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Forwarding

This block sits between a write-through cache and a slower lower-level memory. Stores from the processor side are queued as address/data pairs, so bursts of writes do not stall the processor while the memory is busy. Queued stores go to memory oldest first over a request/acknowledge port, with at most one memory transaction in flight.

Processor reads take precedence over queued stores. Every accepted read first searches all held entries for its address. On a match the youngest matching entry answers the read directly, so a read that follows a store to the same address sees the newest value. A read that matches nothing is sent to memory ahead of every store still waiting, as soon as the transaction already in flight has finished. A store to an address that is already held becomes a new entry; entries are never merged.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_req`, `rd_ack` and `wr_stall` are all 0.
- R2: While fewer than DEPTH entries are held, a write (`wr_req` high) is taken at the next clock edge with `wr_stall` low.
- R3: Stored entries reach memory as write transactions (`mem_we`=1) in arrival order, one at a time. Each request holds its address, `mem_we` and write data stable until the cycle in which `mem_ack` is seen.
- R4: When DEPTH entries are held and no entry is retired in that cycle, `wr_stall` is high during `wr_req` and the write is not taken. It is taken once an entry has been acknowledged by memory.
- R5: A read whose address matches a held entry is answered by the youngest matching entry. `rd_ack` rises one cycle after the read is taken, and no memory transaction is issued for it.
- R6: A read that matches no entry becomes a memory read (`mem_we`=0). It is issued as the next memory transaction after the one in flight, ahead of all older held writes.
- R7: `rd_ack` is a one-cycle pulse with the read data on `rd_rdata`. For a memory read it follows the cycle in which `mem_ack` is seen, and it carries `mem_rdata` from that cycle.
- R8: Two writes to the same address are not merged: both reach memory as separate transactions in arrival order, the later value last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Store request, held until taken |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Store not taken this cycle because the buffer is full |
| rd_req | input | 1 | Read request, held until `rd_ack` |
| rd_addr | input | AW | Read address |
| rd_ack | output | 1 | One-cycle pulse: read result valid |
| rd_rdata | output | DW | Read result |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write transaction, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
A wrong head or tail pointer or occupancy count shows at the memory port as a missing, repeated or reordered store, or as a stall that is missing or raised while the buffer is not full. These errors appear at the next drain or at the DEPTH-th write. A search that picks the wrong entry shows as stale data on the first read to a duplicated address, one cycle after that read is taken. An arbitration error shows as a queued store reaching memory between an in-flight store and a pending read.

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [DW-1:0] rd_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} port_state_t;

  port_state_t      state;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             rd_wait;
  logic [AW-1:0]    rd_addr_q;
  logic             fwd_hit;
  logic [DW-1:0]    fwd_data;
  logic [PTR_W-1:0] idx;

  wire full   = (count == CNT_W'(DEPTH));
  wire push   = wr_req && !full;
  wire pop    = (state == S_WR) && mem_ack;
  wire rd_acc = rd_req && !rd_wait && !rd_ack;

  assign wr_stall  = wr_req && full;
  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_RD) ? rd_addr_q : addr_q[head];
  assign mem_wdata = data_q[head];

  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    idx      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PTR_W'(i);
      if (CNT_W'(i) < count && addr_q[idx] == rd_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = data_q[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= wr_addr;
      data_q[tail] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
      if (pop)  head <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rd_wait   <= 1'b0;
      rd_addr_q <= '0;
      rd_ack    <= 1'b0;
      rd_rdata  <= '0;
    end else begin
      rd_ack <= 1'b0;
      case (state)
        S_IDLE: if (rd_wait) state <= S_RD;
                else if (count != '0) state <= S_WR;
        S_WR:   if (mem_ack) state <= S_IDLE;
        S_RD:   if (mem_ack) begin
                  state    <= S_IDLE;
                  rd_wait  <= 1'b0;
                  rd_ack   <= 1'b1;
                  rd_rdata <= mem_rdata;
                end
        default: state <= S_IDLE;
      endcase
      if (rd_acc) begin
        if (fwd_hit) begin
          rd_ack   <= 1'b1;
          rd_rdata <= fwd_data;
        end else begin
          rd_wait   <= 1'b1;
          rd_addr_q <= rd_addr;
        end
      end
    end
  end

  // R3: request fields hold until acknowledged
  a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata))));

  // R4: occupancy never exceeds the entry count
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R4: a full buffer stays full until memory retires an entry
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

  // R6: a pending read wins arbitration over held writes
  a_r6_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rd_wait) |=> (mem_req && !mem_we));

  // R5: a forwarded read issues no memory read of its own
  a_r5_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && fwd_hit) |=> (rd_ack && !rd_wait));

  // R7: read completion is a single-cycle pulse
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);
endmodule

// File: tb/test_store_fwd_buffer.sv
module test_store_fwd_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_stall;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_ack;
  logic [DW-1:0] rd_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack;
  logic [DW-1:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_fwd_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_store_fwd_buffer (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_rdata(rd_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // behavioural memory with random latency and a transaction log
  logic [DW-1:0] mem [1 << AW];
  logic [DW-1:0] shadow [1 << AW];
  logic          lg_we [LOGN];
  logic [AW-1:0] lg_a [LOGN];
  logic [DW-1:0] lg_d [LOGN];
  int lg_n = 0;
  int lat = 0;
  bit hold = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !hold) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (lg_n < LOGN) begin
          lg_we[lg_n] = mem_we; lg_a[lg_n] = mem_addr; lg_d[lg_n] = mem_wdata;
          lg_n++;
        end
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else mem_rdata <= mem[mem_addr];
        lat = $urandom_range(0, 3);
      end else lat--;
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (wr_stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_req = 1'b0;
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag, output int waited);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; waited = 0;
    do begin @(negedge clk); waited++; end while (!rd_ack && waited < 200);
    rd_req = 1'b0;
    chk(rd_rdata == shadow[a], tag, rd_rdata, shadow[a]);
    @(negedge clk);
    chk(rd_ack == 1'b0, "R7 ack pulse", DW'(rd_ack), '0);
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 4) begin
      @(negedge clk);
      if (mem_req) idle = 0; else idle++;
    end
  endtask

  task automatic t_reset();
    chk(mem_req == 1'b0, "R1 mem_req", DW'(mem_req), '0);
    chk(rd_ack == 1'b0, "R1 rd_ack", DW'(rd_ack), '0);
    chk(wr_stall == 1'b0, "R1 wr_stall", DW'(wr_stall), '0);
  endtask

  task automatic t_fill_stall();
    int base = lg_n;
    hold = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_req = 1'b1; wr_addr = AW'(8'h20 + i); wr_data = 32'hA000 + i;
      #1;
      chk(wr_stall == 1'b0, "R2 no stall below depth", DW'(wr_stall), '0);
      @(posedge clk); #1;
      wr_req = 1'b0;
      shadow[AW'(8'h20 + i)] = 32'hA000 + i;
    end
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 8'h30; wr_data = 32'hBEEF;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(wr_stall == 1'b1, "R4 stall when full", DW'(wr_stall), 1);
      @(negedge clk);
    end
    chk(lg_n == base, "R4 nothing drained while held", DW'(lg_n - base), '0);
    hold = 1'b0;
    #1;
    while (wr_stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_req = 1'b0;
    shadow[8'h30] = 32'hBEEF;
    drain();
    chk(lg_n - base == DEPTH + 1, "R3 drain count", DW'(lg_n - base), DEPTH + 1);
    for (int i = 0; i < DEPTH; i++)
      chk(lg_we[base+i] && lg_a[base+i] == AW'(8'h20 + i) && lg_d[base+i] == 32'hA000 + i,
          "R3 drain order", lg_d[base+i], 32'hA000 + i);
    chk(lg_a[base+DEPTH] == 8'h30 && lg_d[base+DEPTH] == 32'hBEEF,
        "R4 stalled write taken later", lg_d[base+DEPTH], 32'hBEEF);
  endtask

  task automatic t_forward();
    int base = lg_n;
    int w;
    hold = 1'b1;
    do_write(8'h41, 32'h1111);
    do_write(8'h42, 32'h2222);
    do_write(8'h41, 32'h3333);
    do_read(8'h41, "R5 youngest match", w);
    chk(w == 1, "R5 hit latency", DW'(w), 1);
    do_read(8'h42, "R5 single match", w);
    chk(w == 1, "R5 hit latency", DW'(w), 1);
    chk(lg_n == base, "R5 no memory access", DW'(lg_n - base), '0);
    hold = 1'b0;
    drain();
    chk(lg_n - base == 3, "R8 three transactions", DW'(lg_n - base), 3);
    chk(lg_a[base] == 8'h41 && lg_d[base] == 32'h1111, "R8 first value", lg_d[base], 32'h1111);
    chk(lg_a[base+2] == 8'h41 && lg_d[base+2] == 32'h3333, "R8 later value last",
        lg_d[base+2], 32'h3333);
    chk(mem[8'h41] == 32'h3333, "R8 memory final", mem[8'h41], 32'h3333);
  endtask

  task automatic t_read_priority();
    int base = lg_n;
    int w;
    mem[8'h55] = 32'h5555_AAAA;
    shadow[8'h55] = 32'h5555_AAAA;
    hold = 1'b1;
    do_write(8'h61, 32'h61);
    do_write(8'h62, 32'h62);
    do_write(8'h63, 32'h63);
    fork
      do_read(8'h55, "R7 memory read data", w);
      begin repeat (3) @(negedge clk); hold = 1'b0; end
    join
    chk(lg_n - base == 2, "R6 read done before older writes", DW'(lg_n - base), 2);
    drain();
    chk(lg_we[base] && lg_a[base] == 8'h61, "R6 in-flight write first", DW'(lg_a[base]), 32'h61);
    chk(!lg_we[base+1] && lg_a[base+1] == 8'h55, "R6 read next", DW'(lg_a[base+1]), 32'h55);
    chk(lg_we[base+2] && lg_a[base+2] == 8'h62, "R6 writes resume", DW'(lg_a[base+2]), 32'h62);
    chk(lg_we[base+3] && lg_a[base+3] == 8'h63, "R3 order kept", DW'(lg_a[base+3]), 32'h63);
  endtask

  task automatic t_stream();
    int w;
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 9) < 6) do_write(a, $urandom);
      else do_read(a, "R5 R7 mixed traffic", w);
    end
    drain();
    for (int a = 0; a < 16; a++)
      chk(mem[a] == shadow[a], "R3 final memory image", mem[a], shadow[a]);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin mem[a] = '0; shadow[a] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_stall();
    t_forward();
    t_read_priority();
    t_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule